// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the host-facing register front end of an eight-input programmable interrupt controller. A synchronous bus, sampled on the system clock, carries a select, a read strobe, a write strobe, one address bit and a data byte. The decoder runs the initialization word sequence and holds the configuration fields that sequence loads. It also keeps the interrupt mask, the special mask flag and the status read selection.

After initialization, writes are sorted into three kinds: mask loads, priority or end-of-interrupt commands, and read-control commands. Priority and end-of-interrupt commands are handed to the priority logic as one-cycle strobes that carry their data byte. The request register, the in-service register and the resolver's highest pending level come in from the neighbouring blocks. Reads return the request register, the in-service register, the mask, or a poll word. A poll read also raises a one-cycle strobe, so that the acknowledge block can mark that level as in service.

Top module: `irqc_cmd_decoder`

## Requirements
- R1: After reset, `cfg_ready`, `init_stb`, `ocw2_stb` and `poll_stb` are 0, and `imr_out` and `bus_rdata` are 0x00.
- R2: A write with `bus_a0`=0 and data bit 4 set starts initialization and has these effects one cycle later:
  - `init_stb` is high for exactly one cycle and `cfg_ready` is 0.
  - `imr_out` and `special_mask` are cleared and the status read selection returns to the request register.
  - `cfg_cascade` becomes 0x07.
  - Data bits 7:5 load `cfg_vec_hi`, bit 3 loads `cfg_ltim`, bit 2 loads `cfg_adi` and bit 1 loads `cfg_single`.
- R3: The writes that follow with `bus_a0`=1 are taken in order:
  - The second word loads `cfg_vec_byte`.
  - A third word loads `cfg_cascade`, but only when `cfg_single`=0.
  - A fourth word is expected only when bit 0 of the first word was 1.
  - `cfg_ready` rises in the cycle after the last expected word.
- R4: When bit 0 of the first word is 0, `cfg_sfnm`, `cfg_buffered`, `cfg_aeoi` and `cfg_mode86` are cleared, and so is the stored master/slave bit.
- R5: A first word written partway through a sequence restarts it, and the later words follow the conditions of the new first word.
- R6: In the fourth word, bit 4 loads `cfg_sfnm`, bit 3 loads `cfg_buffered`, bit 2 loads the master/slave bit, bit 1 loads `cfg_aeoi` and bit 0 loads `cfg_mode86`.
- R7: When `cfg_ready`=1, a write with `bus_a0`=1 loads `imr_out` in the next cycle. The mask changes only through such a write or through R2.
- R8: A write with `bus_a0`=0 and data bits 4:3 = 00 behaves as follows:
  - When `cfg_ready`=1, `ocw2_stb` is high for one cycle with `ocw2_data` equal to the byte, and the mask is left unchanged.
  - Before `cfg_ready`=1, the write raises no strobe.
- R9: A write with `bus_a0`=0 and data bits 4:3 = 01, made when `cfg_ready`=1, has these effects:
  - Bit 6 = 1 sets `special_mask` to bit 5; bit 6 = 0 leaves it unchanged.
  - Bit 1 = 1 selects the status source from bit 0 (1 = in-service register, 0 = request register); bit 1 = 0 keeps the selection.
  - Bit 2 is the poll request.
- R10: Read data appears on `bus_rdata` one cycle after the read strobe:
  - A read with `bus_a0`=1 returns `imr_out`.
  - A read with `bus_a0`=0 returns the selected status register. The selection persists across reads.
- R11: While a poll is pending, the next read with `bus_a0`=0 behaves as follows:
  - It returns the poll word: bit 7 = `req_valid_in`, bits 6:3 = 0, bits 2:0 = `req_level_in`.
  - It pulses `poll_stb` for one cycle and clears the pending poll.
  - A read with `bus_a0`=1 leaves the poll pending.
- R12: `cfg_master` is set as follows:
  - When `cfg_buffered`=1, it equals the stored master/slave bit.
  - When `cfg_buffered`=0, it follows `sp_en_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus select, qualifies read and write |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_a0 | input | 1 | Address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| irr_in | input | 8 | Request register from the request block |
| isr_in | input | 8 | In-service register from the acknowledge block |
| req_valid_in | input | 1 | Resolver has a pending request |
| req_level_in | input | 3 | Highest pending level from the resolver |
| sp_en_in | input | 1 | Master/slave strap when not buffered |
| cfg_ready | output | 1 | Initialization complete |
| init_stb | output | 1 | One-cycle pulse on first-word acceptance |
| cfg_ltim | output | 1 | Level-triggered inputs |
| cfg_adi | output | 1 | Call address interval of 4 |
| cfg_single | output | 1 | Single controller, no cascade word |
| cfg_vec_hi | output | 3 | Vector address bits from first word |
| cfg_vec_byte | output | 8 | Vector byte from second word |
| cfg_cascade | output | 8 | Cascade map or slave ID |
| cfg_sfnm | output | 1 | Special fully nested mode |
| cfg_buffered | output | 1 | Buffered mode |
| cfg_aeoi | output | 1 | Automatic end of interrupt |
| cfg_mode86 | output | 1 | Two-acknowledge processor mode |
| cfg_master | output | 1 | Resolved master role |
| imr_out | output | 8 | Interrupt mask |
| special_mask | output | 1 | Special mask mode active |
| ocw2_stb | output | 1 | One-cycle priority/EOI command strobe |
| ocw2_data | output | 8 | Byte of the last priority/EOI command |
| poll_stb | output | 1 | One-cycle pulse on a poll read |

## Verification
Some rules are checked by assertions on every cycle:
- The initialization pulse always comes with a cleared mask, a cleared special mask, slave ID 7 and the ready flag low.
- The command strobe is seen only when ready.
- The mask changes only through a mask write or through initialization.
- The ready flag rises only after an address-one write and falls only with the initialization pulse.
- The poll strobe never lasts two cycles.

Other behaviour can only be shown by the bench's scenarios:
- The conditional skipping of the third and fourth words, and the restart in mid-sequence.
- The field positions of each word.
- The persistence of the read selection, and the poll word's contents and single use.
- The role resolution against the strap input.

// File: rtl/irqc_cmd_pkg.sv
`timescale 1ns/1ps
package irqc_cmd_pkg;
   localparam int BYTE_W   = 8;
   // write sorting bits
   localparam int KIND_BIT = 4;
   localparam int OCW3_BIT = 3;
   // first word
   localparam int W1_LTIM  = 3;
   localparam int W1_ADI   = 2;
   localparam int W1_SNGL  = 1;
   localparam int W1_IC4   = 0;
   // fourth word
   localparam int W4_SFNM  = 4;
   localparam int W4_BUF   = 3;
   localparam int W4_MS    = 2;
   localparam int W4_AEOI  = 1;
   localparam int W4_MODE  = 0;
   // read control command
   localparam int C3_ESMM  = 6;
   localparam int C3_SMM   = 5;
   localparam int C3_POLL  = 2;
   localparam int C3_RR    = 1;
   localparam int C3_RIS   = 0;

   typedef enum logic [2:0] {
      SEQ_OFF, SEQ_W2, SEQ_W3, SEQ_W4, SEQ_RUN
   } seq_t;

   typedef struct packed {
      logic sfnm;
      logic buf_en;
      logic ms;
      logic aeoi;
      logic mode86;
   } w4_t;
endpackage

// File: rtl/irqc_init_seq.sv
`timescale 1ns/1ps
module irqc_init_seq
   import irqc_cmd_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SLV_RST = 7,
   localparam int VHI_W  = DATA_W - 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ev,
   input  logic              wr_a0,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              icw1_hit,
   output logic              ready,
   output logic              init_stb,
   output logic              ltim,
   output logic              adi,
   output logic              single,
   output logic [VHI_W-1:0]  vec_hi,
   output logic [DATA_W-1:0] vec_byte,
   output logic [DATA_W-1:0] cascade,
   output w4_t               cfg4
);
   seq_t state;
   logic need4;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SEQ_OFF;
         init_stb <= 1'b0;
         ltim     <= 1'b0;
         adi      <= 1'b0;
         single   <= 1'b0;
         need4    <= 1'b0;
         vec_hi   <= '0;
         vec_byte <= '0;
         cascade  <= '0;
         cfg4     <= '0;
      end else begin
         init_stb <= icw1_hit;
         if (icw1_hit) begin
            state   <= SEQ_W2;
            ltim    <= wr_data[W1_LTIM];
            adi     <= wr_data[W1_ADI];
            single  <= wr_data[W1_SNGL];
            need4   <= wr_data[W1_IC4];
            vec_hi  <= wr_data[DATA_W-1:5];
            cascade <= DATA_W'(SLV_RST);
            if (!wr_data[W1_IC4]) cfg4 <= '0;
         end else if (wr_ev && wr_a0) begin
            case (state)
               SEQ_W2: begin
                  vec_byte <= wr_data;
                  if (!single)    state <= SEQ_W3;
                  else if (need4) state <= SEQ_W4;
                  else            state <= SEQ_RUN;
               end
               SEQ_W3: begin
                  cascade <= wr_data;
                  state   <= need4 ? SEQ_W4 : SEQ_RUN;
               end
               SEQ_W4: begin
                  cfg4.sfnm   <= wr_data[W4_SFNM];
                  cfg4.buf_en <= wr_data[W4_BUF];
                  cfg4.ms     <= wr_data[W4_MS];
                  cfg4.aeoi   <= wr_data[W4_AEOI];
                  cfg4.mode86 <= wr_data[W4_MODE];
                  state       <= SEQ_RUN;
               end
               default: ;
            endcase
         end
      end
   end

   assign ready = (state == SEQ_RUN);
endmodule

// File: rtl/irqc_op_regs.sv
`timescale 1ns/1ps
module irqc_op_regs
   import irqc_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ev,
   input  logic              wr_a0,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              icw1_hit,
   input  logic              ready,
   input  logic              poll_take,
   output logic [DATA_W-1:0] imr,
   output logic              smm,
   output logic              rsel_isr,
   output logic              poll_pend,
   output logic              ocw2_stb,
   output logic [DATA_W-1:0] ocw2_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr       <= '0;
         smm       <= 1'b0;
         rsel_isr  <= 1'b0;
         poll_pend <= 1'b0;
         ocw2_stb  <= 1'b0;
         ocw2_data <= '0;
      end else begin
         ocw2_stb <= 1'b0;
         if (poll_take) poll_pend <= 1'b0;
         if (icw1_hit) begin
            imr       <= '0;
            smm       <= 1'b0;
            rsel_isr  <= 1'b0;
            poll_pend <= 1'b0;
         end else if (wr_ev && ready) begin
            if (wr_a0) begin
               imr <= wr_data;
            end else if (!wr_data[OCW3_BIT]) begin
               ocw2_stb  <= 1'b1;
               ocw2_data <= wr_data;
            end else begin
               if (wr_data[C3_ESMM]) smm      <= wr_data[C3_SMM];
               if (wr_data[C3_RR])   rsel_isr <= wr_data[C3_RIS];
               poll_pend <= wr_data[C3_POLL];
            end
         end
      end
   end
endmodule

// File: rtl/irqc_read_mux.sv
`timescale 1ns/1ps
module irqc_read_mux #(
   parameter int DATA_W    = 8,
   parameter int NUM_IRQ   = 8,
   parameter bit RDATA_REG = 1'b1,
   localparam int LVL_W    = $clog2(NUM_IRQ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_ev,
   input  logic              rd_a0,
   input  logic [DATA_W-1:0] imr,
   input  logic [DATA_W-1:0] irr,
   input  logic [DATA_W-1:0] isr,
   input  logic              rsel_isr,
   input  logic              poll_pend,
   input  logic              req_valid,
   input  logic [LVL_W-1:0]  req_level,
   output logic              poll_take,
   output logic [DATA_W-1:0] rdata,
   output logic              poll_stb
);
   logic [DATA_W-1:0] poll_word;
   logic [DATA_W-1:0] sel_val;

   assign poll_word = {req_valid, {(DATA_W-1-LVL_W){1'b0}}, req_level};
   assign poll_take = rd_ev && !rd_a0 && poll_pend;

   always_comb begin
      if (rd_a0)          sel_val = imr;
      else if (poll_pend) sel_val = poll_word;
      else if (rsel_isr)  sel_val = isr;
      else                sel_val = irr;
   end

   generate
      if (RDATA_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rdata    <= '0;
               poll_stb <= 1'b0;
            end else begin
               poll_stb <= poll_take;
               if (rd_ev) rdata <= sel_val;
            end
         end
      end else begin : g_comb
         assign rdata    = rd_ev ? sel_val : '0;
         assign poll_stb = poll_take;
      end
   endgenerate
endmodule

// File: rtl/irqc_cmd_decoder.sv
`timescale 1ns/1ps
module irqc_cmd_decoder
   import irqc_cmd_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_IRQ   = 8,
   parameter int SLV_RST   = 7,
   parameter bit RDATA_REG = 1'b1,
   localparam int LVL_W    = $clog2(NUM_IRQ),
   localparam int VHI_W    = DATA_W - 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_a0,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] irr_in,
   input  logic [DATA_W-1:0] isr_in,
   input  logic              req_valid_in,
   input  logic [LVL_W-1:0]  req_level_in,
   input  logic              sp_en_in,
   output logic              cfg_ready,
   output logic              init_stb,
   output logic              cfg_ltim,
   output logic              cfg_adi,
   output logic              cfg_single,
   output logic [VHI_W-1:0]  cfg_vec_hi,
   output logic [DATA_W-1:0] cfg_vec_byte,
   output logic [DATA_W-1:0] cfg_cascade,
   output logic              cfg_sfnm,
   output logic              cfg_buffered,
   output logic              cfg_aeoi,
   output logic              cfg_mode86,
   output logic              cfg_master,
   output logic [DATA_W-1:0] imr_out,
   output logic              special_mask,
   output logic              ocw2_stb,
   output logic [DATA_W-1:0] ocw2_data,
   output logic              poll_stb
);
   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("irqc_cmd_decoder: DATA_W must be 8");
      end
      if (NUM_IRQ != DATA_W) begin : g_bad_irq
         $error("irqc_cmd_decoder: NUM_IRQ must equal DATA_W");
      end
      if (SLV_RST >= NUM_IRQ) begin : g_bad_slv
         $error("irqc_cmd_decoder: SLV_RST out of range");
      end
   endgenerate

   logic wr_ev, rd_ev, icw1_hit;
   logic rsel_isr, poll_pend, poll_take;
   w4_t  cfg4;

   assign wr_ev    = bus_sel && bus_wr && !bus_rd;
   assign rd_ev    = bus_sel && bus_rd && !bus_wr;
   assign icw1_hit = wr_ev && !bus_a0 && bus_wdata[KIND_BIT];

   irqc_init_seq #(.DATA_W(DATA_W), .SLV_RST(SLV_RST)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_a0(bus_a0),
      .wr_data(bus_wdata), .icw1_hit(icw1_hit), .ready(cfg_ready),
      .init_stb(init_stb), .ltim(cfg_ltim), .adi(cfg_adi),
      .single(cfg_single), .vec_hi(cfg_vec_hi), .vec_byte(cfg_vec_byte),
      .cascade(cfg_cascade), .cfg4(cfg4)
   );

   irqc_op_regs #(.DATA_W(DATA_W)) u_ops (
      .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_a0(bus_a0),
      .wr_data(bus_wdata), .icw1_hit(icw1_hit), .ready(cfg_ready),
      .poll_take(poll_take), .imr(imr_out), .smm(special_mask),
      .rsel_isr(rsel_isr), .poll_pend(poll_pend), .ocw2_stb(ocw2_stb),
      .ocw2_data(ocw2_data)
   );

   irqc_read_mux #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ),
                   .RDATA_REG(RDATA_REG)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_ev(rd_ev), .rd_a0(bus_a0),
      .imr(imr_out), .irr(irr_in), .isr(isr_in), .rsel_isr(rsel_isr),
      .poll_pend(poll_pend), .req_valid(req_valid_in),
      .req_level(req_level_in), .poll_take(poll_take),
      .rdata(bus_rdata), .poll_stb(poll_stb)
   );

   assign cfg_sfnm     = cfg4.sfnm;
   assign cfg_buffered = cfg4.buf_en;
   assign cfg_aeoi     = cfg4.aeoi;
   assign cfg_mode86   = cfg4.mode86;
   assign cfg_master   = cfg4.buf_en ? cfg4.ms : sp_en_in;
endmodule

// File: rtl/irqc_cmd_decoder_chk.sv
`timescale 1ns/1ps
module irqc_cmd_decoder_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic              bus_a0,
   input logic              cfg_ready,
   input logic              init_stb,
   input logic [DATA_W-1:0] cfg_cascade,
   input logic [DATA_W-1:0] imr_out,
   input logic              special_mask,
   input logic              ocw2_stb,
   input logic [DATA_W-1:0] ocw2_data,
   input logic              poll_stb
);
   // R1
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_stb && ocw2_stb));

   // R2
   init_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_stb |-> (imr_out == '0 && !special_mask && !cfg_ready
                    && cfg_cascade == DATA_W'(7)));

   // R3
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_ready) |-> $past(bus_sel && bus_wr && bus_a0));

   // R5
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_ready) |-> init_stb);

   // R7
   mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(imr_out) |-> (init_stb || $past(bus_sel && bus_wr && bus_a0 && cfg_ready)));

   // R8
   ocw2_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ocw2_stb |-> (cfg_ready && ocw2_data[4:3] == 2'b00));

   // R11
   poll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_stb |=> !poll_stb);
endmodule

bind irqc_cmd_decoder irqc_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/irqc_cmd_decoder_bench.sv
`timescale 1ns/1ps
module irqc_cmd_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 0, bus_wr = 0, bus_rd = 0, bus_a0 = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic [7:0] irr_in = 8'h3C, isr_in = 8'h81;
   logic       req_valid_in = 0;
   logic [2:0] req_level_in = 0;
   logic       sp_en_in = 0;
   logic       cfg_ready, init_stb, cfg_ltim, cfg_adi, cfg_single;
   logic [2:0] cfg_vec_hi;
   logic [7:0] cfg_vec_byte, cfg_cascade, imr_out, ocw2_data;
   logic       cfg_sfnm, cfg_buffered, cfg_aeoi, cfg_mode86, cfg_master;
   logic       special_mask, ocw2_stb, poll_stb;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   irqc_cmd_decoder u_irqc_cmd_decoder (.*);

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a0, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_a0 = a0; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic a0, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_a0 = a0;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      chk("R1 ready", cfg_ready, 0);
      chk("R1 imr", imr_out, 0);
      chk("R1 rdata", bus_rdata, 0);
      chk("R1 strobes", {init_stb, ocw2_stb, poll_stb}, 0);
   endtask

   task automatic t_full_init;
      wr(0, 8'h11);
      chk("R2 init_stb", init_stb, 1);
      chk("R2 slave id", cfg_cascade, 8'h07);
      wr(1, 8'h20);
      chk("R3 vec byte", cfg_vec_byte, 8'h20);
      chk("R3 wait w3", cfg_ready, 0);
      wr(1, 8'h0F);
      chk("R3 cascade", cfg_cascade, 8'h0F);
      chk("R3 wait w4", cfg_ready, 0);
      wr(1, 8'h1F);
      chk("R3 ready", cfg_ready, 1);
      chk("R6 fields", {cfg_sfnm, cfg_buffered, cfg_aeoi, cfg_mode86}, 4'hF);
      chk("R12 buffered master", cfg_master, 1);
      wr(1, 8'hA5);
      chk("R7 mask", imr_out, 8'hA5);
      wr(0, 8'h68);
      chk("R9 smm set", special_mask, 1);
   endtask

   task automatic t_reinit;
      logic [7:0] d;
      wr(0, 8'h0B);
      rd(0, d);
      chk("R10 isr selected", d, 8'h81);
      wr(0, 8'hBA);
      chk("R2 pulse", init_stb, 1);
      chk("R2 mask clr", imr_out, 0);
      chk("R2 smm clr", special_mask, 0);
      chk("R2 fields", {cfg_vec_hi, cfg_ltim, cfg_adi, cfg_single}, 6'b101_1_0_1);
      chk("R2 slave id", cfg_cascade, 8'h07);
      chk("R4 w4 cleared", {cfg_sfnm, cfg_buffered, cfg_aeoi, cfg_mode86}, 0);
      @(negedge clk);
      chk("R2 one cycle", init_stb, 0);
      rd(0, d);
      chk("R2 irr selected", d, 8'h3C);
      wr(0, 8'h20);
      chk("R8 no strobe before ready", ocw2_stb, 0);
      wr(1, 8'h40);
      chk("R3 single no w4 ready", cfg_ready, 1);
      chk("R3 vec byte", cfg_vec_byte, 8'h40);
      sp_en_in = 1;
      #1 chk("R12 strap", cfg_master, 1);
      sp_en_in = 0;
      #1 chk("R12 strap low", cfg_master, 0);
   endtask

   task automatic t_restart;
      wr(0, 8'h11);
      wr(1, 8'h22);
      wr(0, 8'h13);
      chk("R5 restart pulse", init_stb, 1);
      wr(1, 8'h33);
      chk("R5 vec byte", cfg_vec_byte, 8'h33);
      chk("R5 skip w3", cfg_cascade, 8'h07);
      chk("R5 wait w4", cfg_ready, 0);
      wr(1, 8'h08);
      chk("R5 ready", cfg_ready, 1);
      chk("R6 buf only", {cfg_sfnm, cfg_buffered, cfg_aeoi, cfg_mode86}, 4'b0100);
      sp_en_in = 1;
      #1 chk("R12 slave ignores strap", cfg_master, 0);
      sp_en_in = 0;
   endtask

   task automatic t_cmds;
      logic [7:0] d;
      wr(1, 8'h5A);
      wr(0, 8'h20);
      chk("R8 strobe", ocw2_stb, 1);
      chk("R8 data", ocw2_data, 8'h20);
      chk("R8 mask kept", imr_out, 8'h5A);
      @(negedge clk);
      chk("R8 one cycle", ocw2_stb, 0);
      wr(0, 8'h28);
      chk("R9 smm ignored w/o esmm", special_mask, 0);
      rd(1, d);
      chk("R10 mask read", d, 8'h5A);
      rd(0, d);
      chk("R10 irr", d, 8'h3C);
      wr(0, 8'h0B);
      rd(0, d);
      chk("R10 isr", d, 8'h81);
      rd(0, d);
      chk("R10 isr persists", d, 8'h81);
      wr(0, 8'h08);
      rd(0, d);
      chk("R9 rr0 keeps sel", d, 8'h81);
      wr(0, 8'h0A);
      rd(0, d);
      chk("R10 back to irr", d, 8'h3C);
   endtask

   task automatic t_poll;
      logic [7:0] d;
      req_valid_in = 1;
      req_level_in = 3'd5;
      wr(0, 8'h0C);
      rd(1, d);
      chk("R11 a0 read keeps poll", d, 8'h5A);
      chk("R11 no stb on a0 read", poll_stb, 0);
      rd(0, d);
      chk("R11 poll word", d, 8'h85);
      chk("R11 poll stb", poll_stb, 1);
      rd(0, d);
      chk("R11 consumed", d, 8'h3C);
      chk("R11 stb once", poll_stb, 0);
      req_valid_in = 0;
      req_level_in = 3'd7;
      wr(0, 8'h0C);
      rd(0, d);
      chk("R11 no request", d, 8'h07);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_full_init;
      t_reinit;
      t_restart;
      t_cmds;
      t_poll;
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule